// File: doc/BRIEF.md
# Phase-offset PWM timer set

This block generates several high-side PWM waveforms whose edges are shifted in phase against one another. One master timer sets the base period. Every secondary timer is restarted by a sync event, and that event fires a programmable number of cycles after the master period begins. A channel takes its edges from whichever timer it is set to follow, so channels that follow different secondary timers are offset by the gap between their delays.

When a secondary timer reaches the end of its own period before the next sync arrives, it waits at its last count. When a sync comes before the period is complete, the timer restarts at once. This keeps every secondary timer locked to the master period even when its own period is shorter or longer. Period and delay inputs pass through shadow copies, and these copies change only at a master period boundary, so a write made partway through a period cannot cut a pulse short.

Top module: `pwm_phase_timers`

## Requirements
- R1: After reset every timer count reads 0 and every pwm_hi bit is low. Until the first cycle with en high, the active copies of the periods and delays reload from the inputs on every clock.
- R2: In each cycle with en high, the master count steps through 0, 1, ... P-1 and then returns to 0, where P is the active master period (a period of 0 behaves as 1). While en is low, no timer count changes and no sync fires.
- R3: The sync for secondary timer k (k = 0..NUM_SEC-1) fires in the enabled cycle in which the master count equals delay k. A delay of P or more is treated as P-1. On the next cycle that timer reads 0, and it then counts up. A delay of 0 fires in the cycle where the master period begins.
- R4: A synced secondary timer with active period S that reaches S-1 before its next sync keeps reading S-1 until the sync arrives.
- R5: A sync that arrives before a secondary timer reaches S-1 restarts it, so the timer reads 0 on the next cycle.
- R6: The active master period, secondary periods and delays are replaced by the input values only at the clock edge that ends an enabled master cycle with count P-1. At every other edge after the first enabled cycle they keep their values.
- R7: The channel select field picks the reference timer. 0 selects the master timer, j in 1..NUM_SEC selects secondary timer j-1, and any value above NUM_SEC selects the master timer. pwm_hi is registered: in cycle t+1 it is high exactly when the reference count in cycle t was below the duty in cycle t.
- R8: A duty of 0 keeps a channel low. A duty of at least the reference period, and in particular the all-ones duty, keeps it high.
- R9: After reset a secondary timer stays at 0 until its first sync arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Count enable for all timers |
| mst_period | input | CNT_W | Master period, in cycles |
| sec_period | input | NUM_SEC*CNT_W | Secondary periods; timer k in bits [k*CNT_W +: CNT_W] |
| sec_delay | input | NUM_SEC*CNT_W | Sync delays after the master period start; timer k in bits [k*CNT_W +: CNT_W] |
| ch_duty | input | NUM_CH*CNT_W | Per-channel duty (high count) |
| ch_sel | input | NUM_CH*SEL_W | Per-channel reference timer select |
| pwm_hi | output | NUM_CH | High-side PWM outputs |
| mst_count | output | CNT_W | Master timer count |
| sec_count | output | NUM_SEC*CNT_W | Secondary timer counts, timer k in bits [k*CNT_W +: CNT_W] |

## Verification
The bench builds the block with CNT_W = 6, NUM_SEC = 4 and NUM_CH = 6. Six channels against five timers force channels to share a reference timer. The 3-bit select then has spare codes 5 to 7, which must fall back to the master timer. The short 6-bit range keeps master periods small, so a few thousand cycles cover many boundaries. That brings into reach delays clamped at or beyond the period, zero periods, and secondary periods both shorter and longer than the master, which exercise the hold and the early restart. Shadow reloads that land while a sync is pending are covered in the same run.

// File: rtl/pwm_pt_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the phase-offset PWM timer set.
// Assumes: nothing beyond standard SystemVerilog.
package pwm_pt_pkg;
    // Secondary timer sync state: waiting for a first sync, or locked.
    typedef enum logic {
        SEC_IDLE   = 1'b0,
        SEC_SYNCED = 1'b1
    } sec_state_e;
endpackage

// File: rtl/pwm_master_timer.sv
`timescale 1ns/1ps
// Module: pwm_master_timer
// Runs the master period counter, holds the shadow copies of every period
// and delay, and raises one sync strobe per secondary timer each master
// period. A delay at or beyond the master period is clamped to the last count.
// Assumes: inputs are synchronous to clk; reset is synchronous, active low.
module pwm_master_timer #(
    parameter int CNT_W   = 8,
    parameter int NUM_SEC = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en,
    input  logic [CNT_W-1:0]           mper_in,
    input  logic [NUM_SEC*CNT_W-1:0]   sper_in,
    input  logic [NUM_SEC*CNT_W-1:0]   dly_in,
    output logic [CNT_W-1:0]           m_cnt,
    output logic [NUM_SEC*CNT_W-1:0]   sper_act,
    output logic [NUM_SEC-1:0]         trig
);
    localparam int VEC_W = NUM_SEC * CNT_W;

    logic             started;
    logic [CNT_W-1:0] mper_act;
    logic [VEC_W-1:0] dly_act;
    logic [CNT_W-1:0] last_cnt;
    logic [CNT_W:0]   m_inc;
    logic             wrap;
    logic             load;

    // Next count and end-of-period detection (zero period acts as one).
    assign m_inc    = {1'b0, m_cnt} + {{CNT_W{1'b0}}, 1'b1};
    assign wrap     = (m_inc >= {1'b0, mper_act});
    assign load     = !started || (en && wrap);
    assign last_cnt = (mper_act == '0) ? '0 : (mper_act - {{(CNT_W-1){1'b0}}, 1'b1});

    // Master period counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_cnt <= '0;
        end else if (en) begin
            m_cnt <= wrap ? '0 : m_inc[CNT_W-1:0];
        end
    end

    // Remembers that counting has begun, which ends free shadow loading.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started <= 1'b0;
        end else if (en) begin
            started <= 1'b1;
        end
    end

    // Shadow copies of periods and delays, refreshed at period boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mper_act <= '0;
            sper_act <= '0;
            dly_act  <= '0;
        end else if (load) begin
            mper_act <= mper_in;
            sper_act <= sper_in;
            dly_act  <= dly_in;
        end
    end

    // Per-timer clamped delay compare producing the sync strobe.
    for (genvar k = 0; k < NUM_SEC; k++) begin : g_sync
        logic [CNT_W-1:0] dly_k;
        logic [CNT_W-1:0] dly_eff;
        assign dly_k   = dly_act[k*CNT_W +: CNT_W];
        assign dly_eff = (dly_k > last_cnt) ? last_cnt : dly_k;
        assign trig[k] = en && (m_cnt == dly_eff);
    end

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !wrap) |=> (m_cnt == $past(m_inc[CNT_W-1:0])));

    assert_freeze_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!en) |=> $stable(m_cnt));

    assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (started && !(en && wrap)) |=> ($stable(dly_act) && $stable(mper_act) && $stable(sper_act)));

    assert_no_sync_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!en) |-> (trig == '0));
endmodule

// File: rtl/pwm_sec_timer.sv
`timescale 1ns/1ps
// Module: pwm_sec_timer
// One secondary period timer slaved to a sync strobe. A sync restarts it at
// 0 on the next cycle. Once locked, it counts to its period minus one and
// holds there until the next sync. Before its first sync it stays at 0.
// Assumes: trig is a single-cycle strobe qualified by en.
module pwm_sec_timer
    import pwm_pt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             trig,
    input  logic [CNT_W-1:0] per,
    output logic [CNT_W-1:0] cnt
);
    sec_state_e     state;
    logic [CNT_W:0] cnt_inc;
    logic           room;

    // Room to advance exists while the next count is still inside the period.
    assign cnt_inc = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
    assign room    = (cnt_inc < {1'b0, per});

    // Restart on sync, advance while locked, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEC_IDLE;
            cnt   <= '0;
        end else if (en) begin
            if (trig) begin
                state <= SEC_SYNCED;
                cnt   <= '0;
            end else if ((state == SEC_SYNCED) && room) begin
                cnt <= cnt_inc[CNT_W-1:0];
            end
        end
    end

    assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && trig) |=> (cnt == '0));

    assert_hold_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !trig && !room) |=> $stable(cnt));

    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEC_IDLE) |-> (cnt == '0));
endmodule

// File: rtl/pwm_chan_out.sv
`timescale 1ns/1ps
// Module: pwm_chan_out
// One high-side PWM channel. It picks its reference timer from the packed
// count bus (slot 0 is the master) and registers the compare of that count
// against duty. Select codes beyond the secondary range fall back to slot 0.
// Assumes: cnt_all holds NUM_SEC+1 counts, the master in the lowest slot.
module pwm_chan_out #(
    parameter int CNT_W   = 8,
    parameter int NUM_SEC = 4,
    parameter int SEL_W   = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [(NUM_SEC+1)*CNT_W-1:0] cnt_all,
    input  logic [SEL_W-1:0]             sel,
    input  logic [CNT_W-1:0]             duty,
    output logic                         pwm
);
    localparam logic [SEL_W-1:0] SEL_TOP = SEL_W'(NUM_SEC);

    logic [SEL_W-1:0] src;
    logic [CNT_W-1:0] ref_cnt;

    // Out-of-range select codes map to the master timer.
    always_comb begin
        src = (sel > SEL_TOP) ? '0 : sel;
    end

    assign ref_cnt = cnt_all[int'(src)*CNT_W +: CNT_W];

    // Registered duty compare.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm <= 1'b0;
        end else begin
            pwm <= (ref_cnt < duty);
        end
    end

    assert_zero_duty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (duty == '0) |=> !pwm);

    assert_full_duty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (duty == '1) |=> pwm);

    assert_reset_low_R1: assert property (@(posedge clk)
        (!rst_n) |=> !pwm);
endmodule

// File: rtl/pwm_phase_timers.sv
`timescale 1ns/1ps
// Module: pwm_phase_timers (top)
// A master period timer, NUM_SEC secondary timers restarted by delayed syncs,
// and NUM_CH high-side PWM channels, each following one chosen timer.
// Assumes: all inputs are synchronous to clk; reset is synchronous, active low.
module pwm_phase_timers #(
    parameter int CNT_W   = 8,
    parameter int NUM_SEC = 4,
    parameter int NUM_CH  = 4,
    parameter int SEL_W   = $clog2(NUM_SEC + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en,
    input  logic [CNT_W-1:0]          mst_period,
    input  logic [NUM_SEC*CNT_W-1:0]  sec_period,
    input  logic [NUM_SEC*CNT_W-1:0]  sec_delay,
    input  logic [NUM_CH*CNT_W-1:0]   ch_duty,
    input  logic [NUM_CH*SEL_W-1:0]   ch_sel,
    output logic [NUM_CH-1:0]         pwm_hi,
    output logic [CNT_W-1:0]          mst_count,
    output logic [NUM_SEC*CNT_W-1:0]  sec_count
);
    localparam int ALL_W = (NUM_SEC + 1) * CNT_W;

    logic [NUM_SEC*CNT_W-1:0] sper_act;
    logic [NUM_SEC-1:0]       trig;
    logic [ALL_W-1:0]         cnt_all;

    pwm_master_timer #(
        .CNT_W   (CNT_W),
        .NUM_SEC (NUM_SEC)
    ) u_master (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .mper_in  (mst_period),
        .sper_in  (sec_period),
        .dly_in   (sec_delay),
        .m_cnt    (mst_count),
        .sper_act (sper_act),
        .trig     (trig)
    );

    // One slaved timer per delay slot.
    for (genvar k = 0; k < NUM_SEC; k++) begin : g_sec
        pwm_sec_timer #(
            .CNT_W (CNT_W)
        ) u_sec (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en),
            .trig  (trig[k]),
            .per   (sper_act[k*CNT_W +: CNT_W]),
            .cnt   (sec_count[k*CNT_W +: CNT_W])
        );
    end

    assign cnt_all = {sec_count, mst_count};

    // One compare stage per output channel.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pwm_chan_out #(
            .CNT_W   (CNT_W),
            .NUM_SEC (NUM_SEC),
            .SEL_W   (SEL_W)
        ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .cnt_all (cnt_all),
            .sel     (ch_sel[c*SEL_W +: SEL_W]),
            .duty    (ch_duty[c*CNT_W +: CNT_W]),
            .pwm     (pwm_hi[c])
        );
    end
endmodule

// File: tb/sim_pwm_phase_timers.sv
`timescale 1ns/1ps
module sim_pwm_phase_timers;
    localparam int W  = 6;
    localparam int NS = 4;
    localparam int NC = 6;
    localparam int SW = 3;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic            rst_n;
    logic            en;
    logic [W-1:0]    b_mper;
    logic [W-1:0]    b_sper [NS];
    logic [W-1:0]    b_dly  [NS];
    logic [W-1:0]    b_duty [NC];
    logic [SW-1:0]   b_sel  [NC];

    logic [NS*W-1:0] sec_period, sec_delay, sec_count;
    logic [NC*W-1:0] ch_duty;
    logic [NC*SW-1:0] ch_sel;
    logic [NC-1:0]   pwm_hi;
    logic [W-1:0]    mst_count;

    always_comb begin
        for (int k = 0; k < NS; k++) begin
            sec_period[k*W +: W] = b_sper[k];
            sec_delay[k*W +: W]  = b_dly[k];
        end
        for (int c = 0; c < NC; c++) begin
            ch_duty[c*W +: W]  = b_duty[c];
            ch_sel[c*SW +: SW] = b_sel[c];
        end
    end

    pwm_phase_timers #(.CNT_W(W), .NUM_SEC(NS), .NUM_CH(NC)) u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .mst_period(b_mper),
        .sec_period(sec_period), .sec_delay(sec_delay), .ch_duty(ch_duty),
        .ch_sel(ch_sel), .pwm_hi(pwm_hi), .mst_count(mst_count), .sec_count(sec_count)
    );

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    // Reference model state, built from the requirements.
    int md_m, md_mper;
    bit md_started;
    int md_sper [NS];
    int md_dly  [NS];
    int md_s    [NS];
    bit md_sync [NS];
    bit md_pwm  [NC];

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int sec_out(int k);
        return int'(sec_count[k*W +: W]);
    endfunction

    function automatic int eff_dly(int k);
        int lim;
        lim = (md_mper == 0) ? 0 : md_mper - 1;
        return (md_dly[k] > lim) ? lim : md_dly[k];
    endfunction

    function automatic int ref_cnt(int c);
        int s;
        s = int'(b_sel[c]);
        if (s == 0 || s > NS) return md_m;
        return md_s[s-1];
    endfunction

    task automatic model_next();
        bit wrap, ld;
        bit np [NC];
        if (!rst_n) begin
            md_m = 0; md_mper = 0; md_started = 0;
            for (int k = 0; k < NS; k++) begin
                md_sper[k] = 0; md_dly[k] = 0; md_s[k] = 0; md_sync[k] = 0;
            end
            for (int c = 0; c < NC; c++) md_pwm[c] = 0;
            return;
        end
        wrap = (md_m + 1 >= md_mper);
        ld   = !md_started || (en && wrap);
        for (int c = 0; c < NC; c++) np[c] = (ref_cnt(c) < int'(b_duty[c]));
        for (int k = 0; k < NS; k++) begin
            if (en) begin
                if (md_m == eff_dly(k)) begin
                    md_s[k] = 0; md_sync[k] = 1;
                end else if (md_sync[k] && (md_s[k] + 1 < md_sper[k])) begin
                    md_s[k] = md_s[k] + 1;
                end
            end
        end
        if (en) md_m = wrap ? 0 : md_m + 1;
        if (en) md_started = 1;
        if (ld) begin
            md_mper = int'(b_mper);
            for (int k = 0; k < NS; k++) begin
                md_sper[k] = int'(b_sper[k]);
                md_dly[k]  = int'(b_dly[k]);
            end
        end
        for (int c = 0; c < NC; c++) md_pwm[c] = np[c];
    endtask

    task automatic compare(string sec_tag);
        chk(int'(mst_count) == md_m, "R2 master count", int'(mst_count), md_m);
        for (int k = 0; k < NS; k++)
            chk(sec_out(k) == md_s[k], sec_tag, sec_out(k), md_s[k]);
        for (int c = 0; c < NC; c++)
            chk(pwm_hi[c] == md_pwm[c], "R7 channel output", int'(pwm_hi[c]), int'(md_pwm[c]));
    endtask

    // One clock: model advances on the inputs the design sees at the edge.
    task automatic step(string sec_tag);
        model_next();
        @(posedge clk);
        @(negedge clk);
        compare(sec_tag);
    endtask

    task automatic run_until(int v, int maxc);
        int i;
        i = 0;
        do begin
            step("R4 secondary count");
            i++;
        end while (int'(mst_count) != v && i < maxc);
        chk(int'(mst_count) == v, "R2 reach master count", int'(mst_count), v);
    endtask

    initial begin
        #(60000 * 5);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int held_m, held_s;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; en = 1'b0;
        b_mper = 6'd10;
        b_sper[0] = 6'd10; b_sper[1] = 6'd4; b_sper[2] = 6'd20; b_sper[3] = 6'd10;
        b_dly[0] = 6'd0;   b_dly[1] = 6'd3;  b_dly[2] = 6'd0;   b_dly[3] = 6'd30;
        b_duty[0] = 6'd0;  b_duty[1] = 6'd63; b_duty[2] = 6'd5;
        b_duty[3] = 6'd2;  b_duty[4] = 6'd5;  b_duty[5] = 6'd3;
        b_sel[0] = 3'd0; b_sel[1] = 3'd1; b_sel[2] = 3'd2;
        b_sel[3] = 3'd3; b_sel[4] = 3'd4; b_sel[5] = 3'd7;
        @(negedge clk);
        step("R1 reset"); step("R1 reset");
        // R1: reset state at the ports
        chk(mst_count == '0, "R1 master after reset", int'(mst_count), 0);
        chk(sec_count == '0, "R1 secondaries after reset", int'(sec_count), 0);
        chk(pwm_hi == '0, "R1 outputs after reset", int'(pwm_hi), 0);
        rst_n = 1'b1;
        step("R1 idle"); step("R1 idle");
        chk(mst_count == '0, "R1 idle before enable", int'(mst_count), 0);

        en = 1'b1;
        run_until(1, 20);
        chk(sec_out(0) == 0, "R3 delay zero restart", sec_out(0), 0);
        run_until(5, 20);
        chk(sec_out(1) == 1, "R3 delay three offset", sec_out(1), 1);
        run_until(8, 20);
        chk(sec_out(3) == 0, "R9 waits for first sync", sec_out(3), 0);
        run_until(9, 20);
        chk(sec_out(1) == 3, "R4 hold at boundary", sec_out(1), 3);
        chk(sec_out(2) == 8, "R5 long timer mid period", sec_out(2), 8);
        run_until(1, 20);
        chk(sec_out(3) == 1, "R3 clamped delay", sec_out(3), 1);
        chk(sec_out(2) == 0, "R5 early sync reload", sec_out(2), 0);
        chk(pwm_hi[0] == 1'b0, "R8 zero duty low", int'(pwm_hi[0]), 0);
        chk(pwm_hi[1] == 1'b1, "R8 full duty high", int'(pwm_hi[1]), 1);

        b_dly[1] = 6'd7;
        run_until(2, 20);
        chk(pwm_hi[5] == 1'b1, "R7 spare select follows master", int'(pwm_hi[5]), 1);
        run_until(5, 20);
        chk(sec_out(1) == 1, "R6 old delay kept this period", sec_out(1), 1);
        chk(pwm_hi[5] == 1'b0, "R7 spare select low phase", int'(pwm_hi[5]), 0);
        run_until(0, 20);
        run_until(9, 20);
        chk(sec_out(1) == 1, "R6 new delay next period", sec_out(1), 1);

        en = 1'b0;
        held_m = int'(mst_count);
        held_s = sec_out(2);
        repeat (4) step("R2 frozen");
        chk(int'(mst_count) == held_m, "R2 master frozen", int'(mst_count), held_m);
        chk(sec_out(2) == held_s, "R2 secondary frozen", sec_out(2), held_s);
        en = 1'b1;

        // Constrained random phase against the reference model.
        for (int i = 0; i < 5000; i++) begin
            if ($urandom % 32 == 0) begin
                case ($urandom % 5)
                    0: b_mper = 6'($urandom % 24);
                    1: b_sper[$urandom % NS] = 6'($urandom % 32);
                    2: b_dly[$urandom % NS]  = 6'($urandom % 32);
                    3: b_duty[$urandom % NC] = 6'($urandom % 64);
                    default: b_sel[$urandom % NC] = 3'($urandom % 8);
                endcase
            end
            en    = ($urandom % 16) != 0;
            rst_n = ($urandom % 1500) != 0;
            step("R5 secondary count random");
        end
        rst_n = 1'b1;
        step("R1 after random");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule